// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Controller

This block collects up to 32 interrupt inputs and raises a single request line to a processor. A build-time kind mask chooses, per input, whether it is detected on a rising edge or treated as a level. Software sees a small word-addressed register set: a status word, an enable mask, a read-only pending word, a write-one-to-clear acknowledge word and a master control word. Reads return data combinationally from the registered state. Writes take effect on the next clock edge.

Every input pin is registered inside the block. An edge-kind input is detected by comparing the live pin with that stored copy. A level-kind input keeps setting its status bit from the stored copy for as long as the pin stays high. Because of this, an acknowledge cannot erase a level interrupt whose source is still asserting. Capture only runs once software has set the hardware-capture bit in the master word. That bit cannot be cleared again short of reset, and while it is set, direct software writes to the status word are ignored.

Top module: `mixed_irq_ctrl`

## Requirements
- R1: The pending word, read at word offset 1, always equals status AND enable.
- R2: While the hardware-capture bit is set, a level-kind input (kind mask bit 0) sets its status bit at the second clock edge after its pin goes high. The bit stays set for as long as the pin stays high.
- R3: Acknowledging a level-kind bit whose pin is still high leaves the status bit set.
- R4: While the hardware-capture bit is set, an edge-kind input (kind mask bit 1) sets its status bit at the first clock edge on which the pin is high and its stored copy is low. The bit stays set after the pin falls, until it is acknowledged.
- R5: While the hardware-capture bit is clear, no input changes the status word.
- R6: A write to the status word (offset 0) replaces it while the hardware-capture bit is clear, and is ignored while that bit is set.
- R7: Writing the acknowledge word (offset 3) clears each status bit written as 1 and leaves bits written as 0 unchanged. The acknowledge word reads as zero.
- R8: The request output `irq_o` is high exactly when master-enable (bit 0 of the master word, offset 7) is set and the pending word is non-zero.
- R9: The hardware-capture bit (bit 1 of the master word) is set by writing 1 and is cleared only by reset. Writing 0 to it has no effect.
- R10: After reset, all registers read as zero and `irq_o` is low.
- R11: The enable mask is read and written at offset 2. Offsets 4 to 6 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Interrupt source pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench acknowledges a level input while its pin is still high. A design that clears status on acknowledge unconditionally would lose that interrupt until the source pulsed again. It tries to clear the hardware-capture bit, which a non-sticky design would allow, and to overwrite status while capture is on, which a leaky design would accept. It also drops an edge pin before acknowledging, to catch a design that treats edge inputs as levels. Long random phases, before and after capture is enabled, compare every register and the request line against a cycle-level model. These phases expose any error in the one-cycle pin delay, in the pending mask or in unmapped-offset decoding.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned REG_AW = 3;
    localparam int unsigned REG_DW = 32;

    typedef enum logic [REG_AW-1:0] {
        OFS_STATUS = 3'd0,
        OFS_PEND   = 3'd1,
        OFS_ENABLE = 3'd2,
        OFS_ACK    = 3'd3,
        OFS_MASTER = 3'd7
    } irqc_ofs_e;

    localparam int unsigned MSTR_ME_BIT  = 0;
    localparam int unsigned MSTR_HIE_BIT = 1;
endpackage

// File: rtl/irqc_pin_track.sv
module irqc_pin_track #(
    parameter int unsigned N_SRC = 32,
    parameter logic [N_SRC-1:0] KIND_EDGE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    output logic [N_SRC-1:0] rise_o,
    output logic [N_SRC-1:0] lvl_o
);
    logic [N_SRC-1:0] pin_d, pin_q;

    always_comb begin
        pin_d = src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        if (KIND_EDGE[g]) begin : g_edge
            assign rise_o[g] = src_i[g] & ~pin_q[g];
            assign lvl_o[g]  = 1'b0;
        end else begin : g_level
            assign rise_o[g] = 1'b0;
            assign lvl_o[g]  = pin_q[g];
        end
    end

    // R4: an edge is reported only when the stored copy was low
    assert_edge_from_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_o & pin_q) == '0));
    // R2: a level report follows the pin of the previous cycle
    assert_level_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl_o & ~KIND_EDGE) == ($past(src_i) & ~KIND_EDGE)) or $past(!rst_n));
endmodule

// File: rtl/irqc_regbank.sv
module irqc_regbank
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [REG_DW-1:0] wdata_i,
    input  logic [N_SRC-1:0]  rise_i,
    input  logic [N_SRC-1:0]  lvl_i,
    output logic [N_SRC-1:0]  status_o,
    output logic [N_SRC-1:0]  enable_o,
    output logic              me_o,
    output logic              hie_o
);
    typedef struct packed {
        logic [N_SRC-1:0] status;
        logic [N_SRC-1:0] enable;
        logic             me;
        logic             hie;
    } bank_t;

    bank_t st_d, st_q;
    logic  wr_status, wr_ack, wr_enable, wr_master;
    logic [N_SRC-1:0] wbits;

    always_comb begin
        wbits     = wdata_i[N_SRC-1:0];
        wr_status = wr_en_i && (addr_i == OFS_STATUS);
        wr_ack    = wr_en_i && (addr_i == OFS_ACK);
        wr_enable = wr_en_i && (addr_i == OFS_ENABLE);
        wr_master = wr_en_i && (addr_i == OFS_MASTER);

        st_d = st_q;
        if (wr_status && !st_q.hie) st_d.status = wbits;
        if (wr_ack)                 st_d.status = st_d.status & ~wbits;
        if (st_q.hie)               st_d.status = st_d.status | rise_i | lvl_i;
        if (wr_enable)              st_d.enable = wbits;
        if (wr_master) begin
            st_d.me  = wdata_i[MSTR_ME_BIT];
            st_d.hie = st_q.hie | wdata_i[MSTR_HIE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign enable_o = st_q.enable;
    assign me_o     = st_q.me;
    assign hie_o    = st_q.hie;

    // R9: once set, capture enable stays set
    assert_hie_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hie |=> st_q.hie);
    // R5: no capture and no write means status holds
    assert_no_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.hie && !wr_en_i) |=> $stable(st_q.status));
    // R6: with capture on, only an acknowledge can drop a status bit
    assert_sw_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hie && !wr_ack) |=> ((st_q.status & $past(st_q.status)) == $past(st_q.status)));
    // R3: a level seen while capture is on is present next cycle
    assert_level_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hie |=> ((st_q.status & $past(lvl_i)) == $past(lvl_i)));
endmodule

// File: rtl/irqc_readout.sv
module irqc_readout
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC = 32
) (
    input  logic [REG_AW-1:0] addr_i,
    input  logic [N_SRC-1:0]  status_i,
    input  logic [N_SRC-1:0]  enable_i,
    input  logic              me_i,
    input  logic              hie_i,
    output logic [N_SRC-1:0]  pend_o,
    output logic [REG_DW-1:0] rdata_o
);
    always_comb begin
        pend_o  = status_i & enable_i;
        rdata_o = '0;
        case (addr_i)
            OFS_STATUS: rdata_o = REG_DW'(status_i);
            OFS_PEND:   rdata_o = REG_DW'(pend_o);
            OFS_ENABLE: rdata_o = REG_DW'(enable_i);
            OFS_MASTER: begin
                rdata_o[MSTR_ME_BIT]  = me_i;
                rdata_o[MSTR_HIE_BIT] = hie_i;
            end
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/mixed_irq_ctrl.sv
module mixed_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned N_SRC = 32,
    parameter logic [N_SRC-1:0] KIND_EDGE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [REG_DW-1:0] reg_wdata_i,
    output logic [REG_DW-1:0] reg_rdata_o,
    output logic              irq_o
);
    logic [N_SRC-1:0] rise, lvl, status, enable, pend;
    logic             me, hie;

    irqc_pin_track #(.N_SRC(N_SRC), .KIND_EDGE(KIND_EDGE)) i_pins (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise), .lvl_o(lvl)
    );

    irqc_regbank #(.N_SRC(N_SRC)) i_bank (
        .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .rise_i(rise), .lvl_i(lvl),
        .status_o(status), .enable_o(enable), .me_o(me), .hie_o(hie)
    );

    irqc_readout #(.N_SRC(N_SRC)) i_read (
        .addr_i(reg_addr_i), .status_i(status), .enable_i(enable),
        .me_i(me), .hie_i(hie), .pend_o(pend), .rdata_o(reg_rdata_o)
    );

    assign irq_o = me && (pend != '0);

    // R8: a request always has an enabled, set status bit behind it
    assert_irq_backed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((status & enable) != '0));
    // R1: pending never shows a bit that is not enabled
    assert_pend_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~enable) == '0));
endmodule

// File: tb/test_mixed_irq_ctrl.sv
`timescale 1ns/100ps
module test_mixed_irq_ctrl;
    localparam int unsigned N = 32;
    localparam logic [N-1:0] KIND = 32'h0000_FFFF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic wr = 1'b0;
    logic [2:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic irq;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    // model state
    logic [31:0] m_st, m_en, m_pin;
    logic m_me, m_hie;

    always #5 clk = ~clk;

    mixed_irq_ctrl #(.N_SRC(N), .KIND_EDGE(KIND)) i_mixed_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return m_st;
            3'd1: return m_st & m_en;
            3'd2: return m_en;
            3'd7: return {30'd0, m_hie, m_me};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return m_me && ((m_st & m_en) != 0);
    endfunction

    task automatic model_reset();
        m_st = '0; m_en = '0; m_pin = '0; m_me = 1'b0; m_hie = 1'b0;
    endtask

    task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d,
                        input logic [31:0] s);
        logic [31:0] nst, nen; logic nme, nhie;
        @(negedge clk);
        wr = w; addr = a; wdata = d; src = s;
        nst = m_st; nen = m_en; nme = m_me; nhie = m_hie;
        if (w && a == 3'd0 && !m_hie) nst = d;
        if (w && a == 3'd3) nst = nst & ~d;
        if (m_hie) nst = nst | (s & ~m_pin & KIND) | (m_pin & ~KIND);
        if (w && a == 3'd2) nen = d;
        if (w && a == 3'd7) begin nme = d[0]; nhie = m_hie | d[1]; end
        @(posedge clk);
        #1;
        m_st = nst; m_en = nen; m_me = nme; m_hie = nhie; m_pin = s;
        wr = 1'b0;
    endtask

    task automatic chk_reg(input logic [2:0] a, input string tag);
        addr = a;
        #0.2;
        checks++;
        if (rdata !== exp_read(a)) begin
            fails++;
            $display("FAIL %s off=%0d actual=%h expected=%h", tag, a, rdata, exp_read(a));
        end
    endtask

    task automatic chk_irq(input string tag);
        checks++;
        if (irq !== exp_irq()) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp_irq());
        end
    endtask

    task automatic chk_val(input logic [2:0] a, input logic [31:0] e, input string tag);
        addr = a;
        #0.2;
        checks++;
        if (rdata !== e) begin
            fails++;
            $display("FAIL %s off=%0d actual=%h expected=%h", tag, a, rdata, e);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr = 1'b0; src = '0;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        void'($urandom(32'd1234));
        model_reset();
        do_reset();
        // R10, R11: reset values and map
        for (int a = 0; a < 8; a++) chk_val(3'(a), 32'd0, "R10 reset");
        chk_irq("R10 reset irq");

        // R5: pins toggle while capture is off
        step(0, 0, 0, 32'h0010_0001);
        step(0, 0, 0, 32'h0010_0001);
        step(0, 0, 0, 32'h0);
        chk_val(3'd0, 32'd0, "R5 no capture");

        // R6: direct status write while capture is off
        step(1, 3'd0, 32'h0000_0005, 0);
        chk_val(3'd0, 32'h5, "R6 write accepted");
        // R7: ack clears only written ones, reads zero
        step(1, 3'd3, 32'h0000_0001, 0);
        chk_val(3'd0, 32'h4, "R7 ack clears");
        chk_val(3'd3, 32'h0, "R7 ack reads zero");
        // R1, R8, R11: enable and master
        step(1, 3'd2, 32'h0000_000C, 0);
        chk_val(3'd2, 32'hC, "R11 enable");
        chk_val(3'd1, 32'h4, "R1 pending");
        step(1, 3'd7, 32'h1, 0);
        chk_irq("R8 irq on");
        checks++; if (irq !== 1'b1) begin fails++; $display("FAIL R8 irq actual=%b expected=1", irq); end
        step(1, 3'd5, 32'hFFFF_FFFF, 0);
        chk_val(3'd5, 32'h0, "R11 unmapped");
        chk_val(3'd0, 32'h4, "R11 unmapped write no effect");
        // R9: set capture, try to clear it
        step(1, 3'd7, 32'h3, 0);
        step(1, 3'd7, 32'h0, 0);
        chk_val(3'd7, 32'h2, "R9 sticky");
        chk_irq("R8 irq off with me clear");
        // R6: write ignored under capture
        step(1, 3'd0, 32'hFFFF_0000, 0);
        chk_val(3'd0, 32'h4, "R6 write ignored");
        // R2, R3: level input 20
        step(0, 0, 0, 32'h0010_0000);
        chk_val(3'd0, 32'h4, "R2 not yet");
        step(0, 0, 0, 32'h0010_0000);
        chk_val(3'd0, 32'h0010_0004, "R2 level set");
        step(1, 3'd3, 32'h0010_0000, 32'h0010_0000);
        chk_val(3'd0, 32'h0010_0004, "R3 ack while high");
        step(0, 0, 0, 0);
        step(1, 3'd3, 32'h0010_0000, 0);
        step(0, 0, 0, 0);
        chk_val(3'd0, 32'h4, "R3 ack after drop");
        // R4: edge input 3
        step(0, 0, 0, 32'h8);
        chk_val(3'd0, 32'hC, "R4 edge set");
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        chk_val(3'd0, 32'hC, "R4 edge held");
        step(1, 3'd3, 32'h8, 0);
        chk_val(3'd0, 32'h4, "R4 edge acked");

        // random phase without capture, then with
        for (int ph = 0; ph < 2; ph++) begin
            do_reset();
            for (int i = 0; i < 3000; i++) begin
                logic [2:0] a; logic [31:0] d; logic w;
                s = ($urandom % 3 == 0) ? $urandom : m_pin;
                w = ($urandom % 4 == 0);
                a = 3'($urandom);
                d = $urandom;
                if (ph == 0 && a == 3'd7) d[1] = 1'b0;
                if (ph == 1 && i == 10) begin w = 1'b1; a = 3'd7; d = 32'h3; end
                step(w, a, d, s);
                chk_irq("R8 random");
                chk_reg(3'($urandom), ph == 0 ? "R5 R6 R7 random" : "R1 R2 R3 R4 random");
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule